// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is a single-master I2C controller that works one byte at a time. A command word carries start, stop, write, read and acknowledge-value bits. An accepted command runs, in order, an optional start or repeated start, eight data bits followed by one acknowledge slot, and an optional stop. When a data command has no stop bit, the block keeps SCL low after the acknowledge slot. The bus stays owned, and the next command can open with a repeated start.

Software watches the transfer-in-progress output `tip` to know when it may issue the next command. A stop sent on its own is a tracked operation of its own. It raises `tip` and keeps it high until the stop condition has finished on the bus. A later command therefore cannot overrun the stop. SCL and SDA are open-drain: an output-enable of 0 pulls the line low and 1 releases it. Every quarter of a bit period lasts `prescale + 1` clock cycles.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `tip` and `bus_busy` are 0, and `scl_oe_n` and `sda_oe_n` are both 1 (lines released).
- R2: A command with `cmd_start` produces SDA falling while SCL is high, before the first data bit. From an owned bus (SCL low), the block first releases SDA, then raises SCL, then pulls SDA low.
- R3: A write sends `tx_byte` MSB first as 8 bits. SDA is stable while SCL is high. A ninth clock follows in which the master releases SDA and stores the line level in `rx_ack` (0 = acknowledged, 1 = not acknowledged).
- R4: A read (`cmd_read` set, `cmd_write` clear) releases SDA for 8 clocks and shifts the sampled bits MSB first into `rx_byte`. It then drives the ninth bit with the level of `cmd_ack_n` (1 = not-acknowledge, SDA released).
- R5: When `cmd_stop` is set with a write or read, a stop condition (SDA rising while SCL is high) follows directly after the acknowledge bit, and both lines end released.
- R6: A write or read without `cmd_stop` ends with SCL held low, `bus_busy` still 1 and no stop condition. A following command with `cmd_start` makes a repeated start.
- R7: A command with only `cmd_stop` set gives the same bus result as the combined case. `tip` is 1 from the cycle after acceptance until the stop condition is complete on the bus.
- R8: `tip` rises in the cycle after a command is accepted and falls only after the last bus operation of that command. Commands presented while `tip` is 1 are ignored.
- R9: `bus_busy` is set after a start condition is seen on the lines and cleared after a stop condition is seen.
- R10: Each quarter bit period lasts `prescale + 1` clock cycles, so SCL stays high for `2*(prescale+1)` cycles in each data or acknowledge bit.
- R11: A command with none of the start, stop, write or read bits set is ignored: `tip` stays 0 and the lines do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | PRESCALE_W | Quarter bit period minus one, in clock cycles |
| cmd_valid | input | 1 | Command strobe, taken only while `tip` is 0 |
| cmd_start | input | 1 | Issue a start or repeated start first |
| cmd_stop | input | 1 | Issue a stop last |
| cmd_write | input | 1 | Transmit `tx_byte` |
| cmd_read | input | 1 | Receive a byte (ignored when `cmd_write` is set) |
| cmd_ack_n | input | 1 | Acknowledge level the master sends after a read |
| tx_byte | input | 8 | Byte to transmit |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe_n | output | 1 | SCL drive, 0 pulls low |
| sda_oe_n | output | 1 | SDA drive, 0 pulls low |
| tip | output | 1 | Transfer in progress |
| rx_byte | output | 8 | Last received byte |
| rx_ack | output | 1 | Acknowledge level sampled after the last write |
| bus_busy | output | 1 | A start has been seen and no stop since |

## Verification
The bench builds the block with `PRESCALE_W` = 8 and drives `prescale` at run time with 3 and 7. Those small values keep a full byte with start and stop to a few hundred cycles, so every scenario fits in a short run. Two different values let the bench measure SCL high time and confirm that it scales with the prescaler. A small slave model on the open-drain wires supplies acknowledge and read-data bits. It can hold SDA low or leave it released, so the bench can force acknowledge, not-acknowledge and arbitrary read patterns.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;

  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_WRITE, BOP_READ} bit_op_t;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_ACK, PH_STOP} phase_t;

  // {scl, sda} line levels for quarter q of a bit operation; SDA never moves in quarter 3
  function automatic logic [1:0] quarter_lines(bit_op_t op, logic [1:0] q, logic d);
    logic hi;
    hi = (q == 2'd1) || (q == 2'd2);
    case (op)
      BOP_START: case (q)
                   2'd0: quarter_lines = 2'b01;
                   2'd1: quarter_lines = 2'b11;
                   2'd2: quarter_lines = 2'b10;
                   default: quarter_lines = 2'b00;
                 endcase
      BOP_STOP:  case (q)
                   2'd0: quarter_lines = 2'b00;
                   2'd1: quarter_lines = 2'b10;
                   default: quarter_lines = 2'b11;
                 endcase
      BOP_WRITE: quarter_lines = {hi, d};
      default:   quarter_lines = {hi, 1'b1};
    endcase
  endfunction

  // phase that follows once the optional start is behind
  function automatic phase_t first_phase(logic with_start, logic with_data, logic with_stop);
    if (with_start)     first_phase = PH_START;
    else if (with_data) first_phase = PH_DATA;
    else if (with_stop) first_phase = PH_STOP;
    else                first_phase = PH_IDLE;
  endfunction

  function automatic bit_op_t phase_op(phase_t ph, logic rd);
    case (ph)
      PH_START: phase_op = BOP_START;
      PH_DATA:  phase_op = rd ? BOP_READ : BOP_WRITE;
      PH_ACK:   phase_op = rd ? BOP_WRITE : BOP_READ;
      default:  phase_op = BOP_STOP;
    endcase
  endfunction

endpackage

// File: rtl/i2c_qtr_timer.sv
`timescale 1ns/1ps
module i2c_qtr_timer #(
  parameter int PRESCALE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [PRESCALE_W-1:0] prescale,
  output logic                  tick
);
  logic [PRESCALE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!en || cnt == '0)   cnt <= prescale;
    else                         cnt <= cnt - 1'b1;
  end

  assign tick = en && (cnt == '0);
endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
module i2c_bit_engine
  import i2c_seq_pkg::*;
#(
  parameter int PRESCALE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic                  go,
  input  bit_op_t               op,
  input  logic                  din,
  input  logic                  sda_in,
  output logic                  done,
  output logic                  dout,
  output logic                  scl_o,
  output logic                  sda_o,
  output logic                  wr_active
);
  logic       active;
  logic       tick;
  logic [1:0] q;
  bit_op_t    op_r;
  logic       d_r;

  i2c_qtr_timer #(.PRESCALE_W(PRESCALE_W)) u_qtr (
    .clk(clk), .rst_n(rst_n), .en(active), .prescale(prescale), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      q      <= 2'd0;
      op_r   <= BOP_STOP;
      d_r    <= 1'b1;
      dout   <= 1'b1;
      scl_o  <= 1'b1;
      sda_o  <= 1'b1;
    end else if (go) begin
      active         <= 1'b1;
      q              <= 2'd0;
      op_r           <= op;
      d_r            <= din;
      {scl_o, sda_o} <= quarter_lines(op, 2'd0, din);
    end else if (tick) begin
      if (q == 2'd2) dout <= sda_in;
      if (q == 2'd3) active <= 1'b0;
      else begin
        q              <= q + 2'd1;
        {scl_o, sda_o} <= quarter_lines(op_r, q + 2'd1, d_r);
      end
    end
  end

  assign done      = tick && (q == 2'd3);
  assign wr_active = active && (op_r == BOP_WRITE);
endmodule

// File: rtl/i2c_byte_seq.sv
`timescale 1ns/1ps
module i2c_byte_seq
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_write,
  input  logic       cmd_read,
  input  logic       cmd_ack_n,
  input  logic [7:0] tx_byte,
  input  logic       bit_done,
  input  logic       bit_dout,
  output logic       go,
  output bit_op_t    op,
  output logic       din,
  output logic       accept,
  output logic       tip,
  output logic [7:0] rx_byte,
  output logic       rx_ack
);
  phase_t     ph, nxt;
  logic       rd, with_data, with_stop, ack_n;
  logic [7:0] sh;
  logic [2:0] bitcnt;

  assign accept = cmd_valid && (ph == PH_IDLE) &&
                  (cmd_start || cmd_stop || cmd_write || cmd_read);

  always_comb begin
    nxt = ph;
    case (ph)
      PH_START: nxt = first_phase(1'b0, with_data, with_stop);
      PH_DATA:  nxt = (bitcnt == 3'd7) ? PH_ACK : PH_DATA;
      PH_ACK:   nxt = with_stop ? PH_STOP : PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      go        <= 1'b0;
      rd        <= 1'b0;
      with_data <= 1'b0;
      with_stop <= 1'b0;
      ack_n     <= 1'b1;
      sh        <= 8'h00;
      bitcnt    <= 3'd0;
      rx_byte   <= 8'h00;
      rx_ack    <= 1'b0;
    end else begin
      go <= 1'b0;
      if (accept) begin
        rd        <= cmd_read && !cmd_write;
        with_data <= cmd_write || cmd_read;
        with_stop <= cmd_stop;
        ack_n     <= cmd_ack_n;
        sh        <= tx_byte;
        bitcnt    <= 3'd0;
        ph        <= first_phase(cmd_start, cmd_write || cmd_read, cmd_stop);
        go        <= 1'b1;
      end else if (bit_done && ph != PH_IDLE) begin
        if (ph == PH_DATA) begin
          sh     <= {sh[6:0], bit_dout};
          bitcnt <= bitcnt + 3'd1;
        end
        if (ph == PH_ACK) begin
          if (rd) rx_byte <= sh;
          else    rx_ack  <= bit_dout;
        end
        ph <= nxt;
        go <= (nxt != PH_IDLE);
      end
    end
  end

  assign op  = phase_op(ph, rd);
  assign din = (ph == PH_ACK) ? ack_n : sh[7];
  assign tip = (ph != PH_IDLE);
endmodule

// File: rtl/i2c_bus_watch.sv
`timescale 1ns/1ps
module i2c_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_busy
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_seen)     bus_busy <= 1'b1;
      else if (stop_seen) bus_busy <= 1'b0;
    end
  end

  assign start_seen = scl_in && scl_q && sda_q && !sda_in;
  assign stop_seen  = scl_in && scl_q && !sda_q && sda_in;
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master
  import i2c_seq_pkg::*;
#(
  parameter int PRESCALE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic                  cmd_valid,
  input  logic                  cmd_start,
  input  logic                  cmd_stop,
  input  logic                  cmd_write,
  input  logic                  cmd_read,
  input  logic                  cmd_ack_n,
  input  logic [7:0]            tx_byte,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  scl_oe_n,
  output logic                  sda_oe_n,
  output logic                  tip,
  output logic [7:0]            rx_byte,
  output logic                  rx_ack,
  output logic                  bus_busy
);
  logic    bit_go, bit_din, bit_done, bit_dout, wr_active, accept;
  logic    start_seen, stop_seen;
  bit_op_t bit_op;

  i2c_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_ack_n(cmd_ack_n),
    .tx_byte(tx_byte), .bit_done(bit_done), .bit_dout(bit_dout),
    .go(bit_go), .op(bit_op), .din(bit_din), .accept(accept),
    .tip(tip), .rx_byte(rx_byte), .rx_ack(rx_ack)
  );

  i2c_bit_engine #(.PRESCALE_W(PRESCALE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .prescale(prescale),
    .go(bit_go), .op(bit_op), .din(bit_din), .sda_in(sda_in),
    .done(bit_done), .dout(bit_dout), .scl_o(scl_oe_n), .sda_o(sda_oe_n),
    .wr_active(wr_active)
  );

  i2c_bus_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_busy(bus_busy)
  );
endmodule

// File: rtl/i2c_cmd_master_chk.sv
`timescale 1ns/1ps
module i2c_cmd_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe_n,
  input logic sda_oe_n,
  input logic tip,
  input logic bus_busy,
  input logic accept,
  input logic wr_active,
  input logic start_seen,
  input logic stop_seen
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tip && !bus_busy) |-> (scl_oe_n && sda_oe_n));

  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_active && $past(wr_active) && scl_oe_n && $past(scl_oe_n)) |-> $stable(sda_oe_n));

  assert_stop_under_tip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |-> tip);

  assert_tip_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tip);

  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> bus_busy);

  assert_busy_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !bus_busy);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n),
  .tip(tip), .bus_busy(bus_busy), .accept(accept), .wr_active(wr_active),
  .start_seen(start_seen), .stop_seen(stop_seen)
);

// File: tb/sim_i2c_cmd_master.sv
`timescale 1ns/1ps
module sim_i2c_cmd_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] prescale = 8'd3;
  logic       cmd_valid = 0, cmd_start = 0, cmd_stop = 0, cmd_write = 0, cmd_read = 0, cmd_ack_n = 0;
  logic [7:0] tx_byte = 8'h00;
  logic       scl_oe_n, sda_oe_n, tip, rx_ack, bus_busy;
  logic [7:0] rx_byte;
  logic       drv = 1'b0;
  wire        scl_line = scl_oe_n;
  wire        sda_line = sda_oe_n & ~drv;

  int nchk = 0, nerr = 0, cyc = 0;
  int start_cnt = 0, stop_cnt = 0, nbits = 0, idx = 9;
  logic [8:0] pat = '0, obs = '0;
  logic stop_tip = 1'b0;
  time t_rise = 0, hi_ns = 0;

  i2c_cmd_master #(.PRESCALE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .prescale(prescale),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_ack_n(cmd_ack_n),
    .tx_byte(tx_byte), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .tip(tip),
    .rx_byte(rx_byte), .rx_ack(rx_ack), .bus_busy(bus_busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  // bus observers and slave model
  always @(negedge sda_line) if (scl_line) begin start_cnt++; idx = 0; drv = 1'b0; nbits = 0; end
  always @(posedge sda_line) if (scl_line) begin stop_cnt++; stop_tip = tip; end
  always @(posedge scl_line) begin
    t_rise = $time;
    if (nbits < 9) begin obs = {obs[7:0], sda_line}; nbits++; end
  end
  always @(negedge scl_line) begin
    hi_ns = $time - t_rise;
    #2;
    if (idx < 9) begin drv = pat[idx]; idx++; end
    else drv = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic arm(input logic [8:0] p, input bit with_start);
    pat = p;
    nbits = 0;
    if (with_start) begin idx = 9; drv = 1'b0; end
    else begin drv = p[0]; idx = 1; end
  endtask

  task automatic issue(input bit s, input bit p, input bit w, input bit r, input bit an, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1; cmd_start = s; cmd_stop = p; cmd_write = w; cmd_read = r; cmd_ack_n = an; tx_byte = b;
    @(negedge clk);
    cmd_valid = 0; cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0;
  endtask

  task automatic wait_idle();
    while (tip) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(tip == 0, "R1", "tip", tip, 0);
    check(scl_oe_n && sda_oe_n, "R1", "lines", {scl_oe_n, sda_oe_n}, 3);
    check(bus_busy == 0, "R1", "bus_busy", bus_busy, 0);
  endtask

  task automatic t_write_stop(input logic [7:0] b, input logic [7:0] ps, input bit slave_ack);
    int s0, p0;
    prescale = ps;
    s0 = start_cnt; p0 = stop_cnt;
    arm(slave_ack ? 9'h100 : 9'h000, 1);
    issue(1, 1, 1, 0, 0, b);
    check(tip == 1, "R8", "tip after accept", tip, 1);
    wait_idle();
    check(start_cnt == s0 + 1, "R2", "start count", start_cnt - s0, 1);
    check(obs[8:1] == b, "R3", "written byte", obs[8:1], b);
    check(rx_ack == !slave_ack, "R3", "rx_ack", rx_ack, !slave_ack);
    check(stop_cnt == p0 + 1, "R5", "stop count", stop_cnt - p0, 1);
    check(scl_oe_n && sda_oe_n, "R5", "lines released", {scl_oe_n, sda_oe_n}, 3);
    check(bus_busy == 0, "R9", "bus_busy after stop", bus_busy, 0);
    check(hi_ns == 20 * (ps + 1), "R10", "scl high ns", int'(hi_ns), 20 * (ps + 1));
  endtask

  task automatic t_hold_then_stop(input logic [7:0] b);
    int p0;
    p0 = stop_cnt;
    arm(9'h100, 1);
    issue(1, 0, 1, 0, 0, b);
    wait_idle();
    check(obs[8:1] == b, "R3", "held write byte", obs[8:1], b);
    check(scl_oe_n == 0, "R6", "scl held low", scl_oe_n, 0);
    check(bus_busy == 1, "R6", "bus still busy", bus_busy, 1);
    check(stop_cnt == p0, "R6", "no stop", stop_cnt - p0, 0);
    stop_tip = 0;
    issue(0, 1, 0, 0, 0, 8'h00);
    check(tip == 1, "R7", "tip on lone stop", tip, 1);
    wait_idle();
    check(stop_cnt == p0 + 1, "R7", "lone stop on bus", stop_cnt - p0, 1);
    check(stop_tip == 1, "R7", "tip during stop", stop_tip, 1);
    check(scl_oe_n && sda_oe_n, "R7", "lines released", {scl_oe_n, sda_oe_n}, 3);
    check(bus_busy == 0, "R9", "bus_busy cleared", bus_busy, 0);
  endtask

  task automatic t_repeated(input logic [7:0] b1, input logic [7:0] b2);
    int s0, p0;
    s0 = start_cnt; p0 = stop_cnt;
    arm(9'h100, 1);
    issue(1, 0, 1, 0, 0, b1);
    wait_idle();
    arm(9'h100, 1);
    issue(1, 1, 1, 0, 0, b2);
    wait_idle();
    check(start_cnt == s0 + 2, "R6", "repeated start count", start_cnt - s0, 2);
    check(stop_cnt == p0 + 1, "R6", "single stop", stop_cnt - p0, 1);
    check(obs[8:1] == b2, "R2", "byte after repeated start", obs[8:1], b2);
  endtask

  task automatic t_read(input logic [7:0] d, input bit an);
    logic [8:0] p;
    for (int i = 0; i < 8; i++) p[i] = ~d[7-i];
    p[8] = 1'b0;
    arm(p, 1);
    issue(1, 1, 0, 1, an, 8'h00);
    wait_idle();
    check(rx_byte == d, "R4", "rx_byte", rx_byte, d);
    check(obs[0] == an, "R4", "master ack bit", obs[0], an);
  endtask

  task automatic t_busy_ignore(input logic [7:0] b);
    int s0;
    s0 = start_cnt;
    arm(9'h100, 1);
    issue(1, 1, 1, 0, 0, b);
    repeat (5) @(negedge clk);
    issue(1, 0, 0, 1, 0, 8'h00);
    wait_idle();
    repeat (20) @(negedge clk);
    check(start_cnt == s0 + 1, "R8", "ignored command starts", start_cnt - s0, 1);
    check(obs[8:1] == b, "R8", "first byte intact", obs[8:1], b);
    check(tip == 0, "R8", "tip idle", tip, 0);
  endtask

  task automatic t_empty();
    int s0;
    s0 = start_cnt;
    issue(0, 0, 0, 0, 1, 8'hFF);
    check(tip == 0, "R11", "tip on empty cmd", tip, 0);
    repeat (10) @(negedge clk);
    check(scl_oe_n && sda_oe_n, "R11", "lines quiet", {scl_oe_n, sda_oe_n}, 3);
    check(start_cnt == s0, "R11", "no start", start_cnt - s0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_stop(8'hA5, 8'd3, 1);
    t_write_stop(8'h3C, 8'd7, 0);
    prescale = 8'd3;
    t_hold_then_stop(8'h96);
    t_repeated(8'h01, 8'hFE);
    t_read(8'hC3, 1'b1);
    t_read(8'h5A, 1'b0);
    t_busy_ignore(8'h81);
    t_empty();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule